// File: doc/BRIEF.md
# Per-IP Security Monitor and Access Gate

This block sits next to one IP and connects it to a central policy engine. During boot the engine writes a few configuration words that choose which of the IP's status flags are watched, which register address of a neighbouring IP counts as a sensitive target, and which of the IP's control lines the engine may override. After boot the configuration can be locked.

At run time the block detects two kinds of event. The first is a rising edge on a selected status flag. The second is a request from the IP to the watched address. Each event is packed into a frame and queued. A flag tells the engine that a frame is waiting. The engine reads the frame as two half-width beats on a dedicated security port, separate from any debug trace path. A request that hits the watched address is held back until the engine decides. The engine can release it once, or it can set a sticky disable that refuses every request from the IP until the engine clears it.

Top module: `sec_wrap`

## Requirements
- R1: After reset all configuration is zero. A write with `cfg_sel`=0 loads the status-flag monitor mask. A write with `cfg_sel`=1 loads the watched address from bits AW-1:0 and its enable from bit AW. A write with `cfg_sel`=2 loads the control-override mask. Each write takes effect at the clock edge where `cfg_we` is sampled.
- R2: A write with `cfg_sel`=3 locks the configuration. Every later configuration write is ignored until reset.
- R3: A 0-to-1 change on a masked `obs` bit queues a frame with event code 2'b01, the source identifier, address field = index of the lowest such rising bit, and read/write bit 0. Unmasked bits produce nothing. `evt_flag` is set in the cycle after the edge is sampled.
- R4: A request with `ip_req`=1 whose `ip_addr` equals the enabled watched address queues a frame with code 2'b10, that address and read/write bit = `ip_we`. The request is withheld from the fabric (`fab_req`=0) in that same cycle. Requests to other addresses pass straight to `fab_req`.
- R5: A frame is the 15-bit vector {code[1:0], source[3:0], address[7:0], rw}, with rw at bit 0. `eng_rd` is sampled while `evt_flag`=1. `evt_dvld` is then high for exactly two cycles, carrying frame bits 7:0 and then {1'b0, bits 14:8}. `evt_flag` clears at the edge after the second beat, unless another frame is queued.
- R6: While a watched access is pending, all IP requests are stalled, with no grant and no deny. An `eng_allow` pulse releases the held request once, without a new event.
- R7: An `eng_dis_set` pulse blocks every IP request from the next cycle on (`fab_req`=0, `ip_deny`=`ip_req`) and suppresses access events. The block holds until an `eng_dis_clr` pulse. If set and clear arrive together, set wins.
- R8: A second event that arrives while a frame is waiting is held in a one-entry buffer. It is presented after the first frame has been read.
- R9: An event that finds both the frame slot and the buffer occupied is dropped and sets `evt_ovf`. `evt_ovf` stays set until reset.
- R10: For each control line i, `ctl_out[i]` is `eng_force[i]` when override-mask bit i is 1, and `ip_ctl[i]` otherwise.
- R11: If an access event and a flag event occur in the same cycle, the access frame is queued ahead of the flag frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration word select (0 mask, 1 watch, 2 override, 3 lock) |
| cfg_wdata | input | CFG_W | Configuration write data |
| obs | input | N_OBS | Observable status flags of the IP |
| ip_req | input | 1 | Access request from the IP |
| ip_addr | input | AW | Target register address of the request |
| ip_we | input | 1 | Request is a write |
| ip_gnt | output | 1 | Grant returned to the IP |
| ip_deny | output | 1 | Request refused by the disable state |
| fab_req | output | 1 | Request forwarded to the fabric |
| fab_addr | output | AW | Forwarded address |
| fab_we | output | 1 | Forwarded write flag |
| fab_gnt | input | 1 | Grant from the fabric |
| ip_ctl | input | N_CTL | Control lines driven by the IP |
| ctl_out | output | N_CTL | Control lines after override |
| eng_force | input | N_CTL | Override values from the engine |
| eng_allow | input | 1 | Engine releases a pending access |
| eng_dis_set | input | 1 | Engine sets the disable state |
| eng_dis_clr | input | 1 | Engine clears the disable state |
| eng_rd | input | 1 | Engine starts reading the waiting frame |
| evt_flag | output | 1 | A frame is waiting |
| evt_dvld | output | 1 | Read beat valid |
| evt_data | output | HW | Read beat data |
| evt_ovf | output | 1 | Sticky event-loss status |

## Verification
Some rules are checked on every cycle. A disable pulse blocks the fabric request on the next cycle, and the refusal persists until a clear. A read always produces exactly two valid beats, and only while the flag is up. Overflow never falls once raised. The directed scenarios cover the rest: exact frame contents and beat order, lowest-index choice among simultaneous flag edges, access-before-flag ordering, one-entry buffering, the stall and single release after an allow, override muxing, and that writes after the lock have no effect on the outputs.

// File: rtl/sec_wrap_pkg.sv
package sec_wrap_pkg;
    typedef enum logic [1:0] {
        EVT_NONE   = 2'b00,
        EVT_FLAG   = 2'b01,
        EVT_ACCESS = 2'b10
    } evt_code_e;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_LO   = 2'd1,
        RD_HI   = 2'd2
    } rd_state_e;

    localparam logic [1:0] CFG_OBS   = 2'd0;
    localparam logic [1:0] CFG_WATCH = 2'd1;
    localparam logic [1:0] CFG_CTL   = 2'd2;
    localparam logic [1:0] CFG_LOCK  = 2'd3;
endpackage

// File: rtl/sec_wrap_cfg.sv
module sec_wrap_cfg
    import sec_wrap_pkg::*;
#(
    parameter int N_OBS = 8,
    parameter int N_CTL = 4,
    parameter int AW    = 8,
    parameter int CFG_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [N_OBS-1:0] obs_mask,
    output logic [AW-1:0]    watch_addr,
    output logic             watch_en,
    output logic [N_CTL-1:0] ctl_mask
);
    typedef struct packed {
        logic [N_OBS-1:0] obs_mask;
        logic [AW-1:0]    watch_addr;
        logic             watch_en;
        logic [N_CTL-1:0] ctl_mask;
        logic             locked;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we && !cfg_q.locked) begin
            case (cfg_sel)
                CFG_OBS:   cfg_d.obs_mask = cfg_wdata[N_OBS-1:0];
                CFG_WATCH: begin
                    cfg_d.watch_addr = cfg_wdata[AW-1:0];
                    cfg_d.watch_en   = cfg_wdata[AW];
                end
                CFG_CTL:   cfg_d.ctl_mask = cfg_wdata[N_CTL-1:0];
                default:   cfg_d.locked = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign obs_mask   = cfg_q.obs_mask;
    assign watch_addr = cfg_q.watch_addr;
    assign watch_en   = cfg_q.watch_en;
    assign ctl_mask   = cfg_q.ctl_mask;
endmodule

// File: rtl/sec_wrap_detect.sv
module sec_wrap_detect #(
    parameter int N_OBS = 8,
    parameter int IW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_OBS-1:0] obs,
    input  logic [N_OBS-1:0] obs_mask,
    output logic             rise_hit,
    output logic [IW-1:0]    rise_idx
);
    logic [N_OBS-1:0] prev_d, prev_q;
    logic [N_OBS-1:0] rise;

    always_comb begin
        prev_d   = obs;
        rise     = obs & ~prev_q & obs_mask;
        rise_hit = |rise;
        rise_idx = '0;
        for (int i = N_OBS - 1; i >= 0; i--) begin
            if (rise[i]) rise_idx = IW'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/sec_wrap_gate.sv
module sec_wrap_gate #(
    parameter int AW    = 8,
    parameter int N_CTL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ip_req,
    input  logic [AW-1:0]    ip_addr,
    input  logic             fab_gnt,
    input  logic [AW-1:0]    watch_addr,
    input  logic             watch_en,
    input  logic             eng_allow,
    input  logic             eng_dis_set,
    input  logic             eng_dis_clr,
    input  logic [N_CTL-1:0] ip_ctl,
    input  logic [N_CTL-1:0] eng_force,
    input  logic [N_CTL-1:0] ctl_mask,
    output logic             acc_hit,
    output logic             fab_req,
    output logic             ip_gnt,
    output logic             ip_deny,
    output logic [N_CTL-1:0] ctl_out
);
    typedef struct packed {
        logic dis;
        logic pend;
        logic pass;
    } gate_t;

    gate_t st_d, st_q;

    always_comb begin
        acc_hit = ip_req && watch_en && (ip_addr == watch_addr)
                  && !st_q.dis && !st_q.pend && !st_q.pass;
        fab_req = ip_req && !st_q.dis && !st_q.pend && !acc_hit;
        ip_gnt  = fab_req && fab_gnt;
        ip_deny = ip_req && st_q.dis;

        st_d = st_q;
        if (eng_dis_set)      st_d.dis = 1'b1;
        else if (eng_dis_clr) st_d.dis = 1'b0;

        if (eng_allow || eng_dis_set) st_d.pend = 1'b0;
        else if (acc_hit)             st_d.pend = 1'b1;

        if (eng_dis_set)                    st_d.pass = 1'b0;
        else if (eng_allow && st_q.pend)    st_d.pass = 1'b1;
        else if (st_q.pass && ip_gnt)       st_d.pass = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < N_CTL; g++) begin : g_ovr
        assign ctl_out[g] = ctl_mask[g] ? eng_force[g] : ip_ctl[g];
    end
endmodule

// File: rtl/sec_wrap_queue.sv
module sec_wrap_queue
    import sec_wrap_pkg::*;
#(
    parameter int FW = 15,
    parameter int HW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push0,
    input  logic [FW-1:0] frame0,
    input  logic          push1,
    input  logic [FW-1:0] frame1,
    input  logic          eng_rd,
    output logic          evt_flag,
    output logic          evt_dvld,
    output logic [HW-1:0] evt_data,
    output logic          evt_ovf
);
    localparam int PW = 2 * HW;

    typedef struct packed {
        logic          va;
        logic [FW-1:0] fa;
        logic          vb;
        logic [FW-1:0] fb;
        rd_state_e     rd;
        logic          ovf;
    } q_t;

    q_t q_d, q_q;
    logic [PW-1:0] head_pad;

    always_comb begin
        q_d = q_q;
        unique case (q_q.rd)
            RD_IDLE: if (eng_rd && q_q.va) q_d.rd = RD_LO;
            RD_LO:   q_d.rd = RD_HI;
            RD_HI: begin
                q_d.rd = RD_IDLE;
                q_d.va = q_q.vb;
                q_d.fa = q_q.fb;
                q_d.vb = 1'b0;
            end
            default: q_d.rd = RD_IDLE;
        endcase

        if (push0) begin
            if (!q_d.va) begin
                q_d.va = 1'b1;
                q_d.fa = frame0;
            end else if (!q_d.vb) begin
                q_d.vb = 1'b1;
                q_d.fb = frame0;
            end else begin
                q_d.ovf = 1'b1;
            end
        end
        if (push1) begin
            if (!q_d.va) begin
                q_d.va = 1'b1;
                q_d.fa = frame1;
            end else if (!q_d.vb) begin
                q_d.vb = 1'b1;
                q_d.fb = frame1;
            end else begin
                q_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '{va: 1'b0, fa: '0, vb: 1'b0, fb: '0, rd: RD_IDLE, ovf: 1'b0};
        else        q_q <= q_d;
    end

    assign head_pad = PW'(q_q.fa);
    assign evt_flag = q_q.va;
    assign evt_dvld = (q_q.rd == RD_LO) || (q_q.rd == RD_HI);
    assign evt_data = (q_q.rd == RD_HI) ? head_pad[PW-1:HW] : head_pad[HW-1:0];
    assign evt_ovf  = q_q.ovf;
endmodule

// File: rtl/sec_wrap.sv
module sec_wrap
    import sec_wrap_pkg::*;
#(
    parameter int N_OBS  = 8,
    parameter int N_CTL  = 4,
    parameter int AW     = 8,
    parameter int SW     = 4,
    parameter int SRC_ID = 5,
    localparam int CFG_W = (N_OBS > AW + 1) ? ((N_OBS > N_CTL) ? N_OBS : N_CTL)
                                            : ((AW + 1 > N_CTL) ? AW + 1 : N_CTL),
    localparam int FW    = 2 + SW + AW + 1,
    localparam int HW    = (FW + 1) / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [N_OBS-1:0] obs,
    input  logic             ip_req,
    input  logic [AW-1:0]    ip_addr,
    input  logic             ip_we,
    output logic             ip_gnt,
    output logic             ip_deny,
    output logic             fab_req,
    output logic [AW-1:0]    fab_addr,
    output logic             fab_we,
    input  logic             fab_gnt,
    input  logic [N_CTL-1:0] ip_ctl,
    output logic [N_CTL-1:0] ctl_out,
    input  logic [N_CTL-1:0] eng_force,
    input  logic             eng_allow,
    input  logic             eng_dis_set,
    input  logic             eng_dis_clr,
    input  logic             eng_rd,
    output logic             evt_flag,
    output logic             evt_dvld,
    output logic [HW-1:0]    evt_data,
    output logic             evt_ovf
);
    localparam int IW = (N_OBS > 1) ? $clog2(N_OBS) : 1;

    logic [N_OBS-1:0] obs_mask;
    logic [AW-1:0]    watch_addr;
    logic             watch_en;
    logic [N_CTL-1:0] ctl_mask;
    logic             rise_hit;
    logic [IW-1:0]    rise_idx;
    logic             acc_hit;
    logic [FW-1:0]    acc_frame;
    logic [FW-1:0]    flag_frame;

    sec_wrap_cfg #(.N_OBS(N_OBS), .N_CTL(N_CTL), .AW(AW), .CFG_W(CFG_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .obs_mask(obs_mask), .watch_addr(watch_addr),
        .watch_en(watch_en), .ctl_mask(ctl_mask)
    );

    sec_wrap_detect #(.N_OBS(N_OBS), .IW(IW)) u_det (
        .clk(clk), .rst_n(rst_n), .obs(obs), .obs_mask(obs_mask),
        .rise_hit(rise_hit), .rise_idx(rise_idx)
    );

    sec_wrap_gate #(.AW(AW), .N_CTL(N_CTL)) u_gate (
        .clk(clk), .rst_n(rst_n), .ip_req(ip_req), .ip_addr(ip_addr),
        .fab_gnt(fab_gnt), .watch_addr(watch_addr), .watch_en(watch_en),
        .eng_allow(eng_allow), .eng_dis_set(eng_dis_set), .eng_dis_clr(eng_dis_clr),
        .ip_ctl(ip_ctl), .eng_force(eng_force), .ctl_mask(ctl_mask),
        .acc_hit(acc_hit), .fab_req(fab_req), .ip_gnt(ip_gnt),
        .ip_deny(ip_deny), .ctl_out(ctl_out)
    );

    assign acc_frame  = {EVT_ACCESS, SW'(SRC_ID), ip_addr, ip_we};
    assign flag_frame = {EVT_FLAG, SW'(SRC_ID), AW'(rise_idx), 1'b0};

    sec_wrap_queue #(.FW(FW), .HW(HW)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push0(acc_hit), .frame0(acc_frame),
        .push1(rise_hit), .frame1(flag_frame),
        .eng_rd(eng_rd), .evt_flag(evt_flag), .evt_dvld(evt_dvld),
        .evt_data(evt_data), .evt_ovf(evt_ovf)
    );

    assign fab_addr = ip_addr;
    assign fab_we   = ip_we;
endmodule

// File: rtl/sec_wrap_chk.sv
module sec_wrap_chk (
    input logic clk,
    input logic rst_n,
    input logic eng_dis_set,
    input logic eng_dis_clr,
    input logic ip_req,
    input logic ip_deny,
    input logic fab_req,
    input logic evt_flag,
    input logic evt_dvld,
    input logic evt_ovf
);
    assert_dis_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_dis_set |=> !fab_req);

    assert_dis_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ip_deny && !eng_dis_clr) |=> (ip_deny || !ip_req));

    assert_deny_not_forwarded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ip_deny |-> !fab_req);

    assert_second_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_dvld) |=> evt_dvld);

    assert_two_beats_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_dvld && $past(evt_dvld)) |=> !evt_dvld);

    assert_beat_has_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_dvld |-> evt_flag);

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_ovf |=> evt_ovf);
endmodule

bind sec_wrap sec_wrap_chk u_chk (
    .clk(clk), .rst_n(rst_n), .eng_dis_set(eng_dis_set), .eng_dis_clr(eng_dis_clr),
    .ip_req(ip_req), .ip_deny(ip_deny), .fab_req(fab_req),
    .evt_flag(evt_flag), .evt_dvld(evt_dvld), .evt_ovf(evt_ovf)
);

// File: tb/sec_wrap_tb.sv
module sec_wrap_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [8:0] cfg_wdata = '0;
    logic [7:0] obs = '0;
    logic       ip_req = 1'b0;
    logic [7:0] ip_addr = '0;
    logic       ip_we = 1'b0;
    logic       ip_gnt, ip_deny, fab_req, fab_we;
    logic [7:0] fab_addr;
    logic       fab_gnt = 1'b0;
    logic [3:0] ip_ctl = '0;
    logic [3:0] ctl_out;
    logic [3:0] eng_force = '0;
    logic       eng_allow = 1'b0, eng_dis_set = 1'b0, eng_dis_clr = 1'b0, eng_rd = 1'b0;
    logic       evt_flag, evt_dvld, evt_ovf;
    logic [7:0] evt_data;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    sec_wrap u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .obs(obs), .ip_req(ip_req), .ip_addr(ip_addr), .ip_we(ip_we),
        .ip_gnt(ip_gnt), .ip_deny(ip_deny), .fab_req(fab_req), .fab_addr(fab_addr),
        .fab_we(fab_we), .fab_gnt(fab_gnt), .ip_ctl(ip_ctl), .ctl_out(ctl_out),
        .eng_force(eng_force), .eng_allow(eng_allow), .eng_dis_set(eng_dis_set),
        .eng_dis_clr(eng_dis_clr), .eng_rd(eng_rd), .evt_flag(evt_flag),
        .evt_dvld(evt_dvld), .evt_data(evt_data), .evt_ovf(evt_ovf)
    );

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [15:0] frame(input logic [1:0] code, input logic [7:0] addr,
                                         input logic rw);
        return {1'b0, code, 4'h5, addr, rw};
    endfunction

    task automatic cfg_write(input logic [1:0] sel, input logic [8:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic read_frame(input string req, output logic [15:0] f);
        logic [7:0] lo;
        eng_rd = 1'b1;
        tick();
        eng_rd = 1'b0;
        check(req, "first beat valid", {31'b0, evt_dvld}, 32'd1);
        lo = evt_data;
        tick();
        check(req, "second beat valid", {31'b0, evt_dvld}, 32'd1);
        f = {evt_data, lo};
        tick();
        check(req, "beats end", {31'b0, evt_dvld}, 32'd0);
    endtask

    task automatic t_reset();
        ip_ctl = 4'b1010; eng_force = 4'b0101;
        #1;
        check("R1", "flag after reset", {31'b0, evt_flag}, 32'd0);
        check("R9", "ovf after reset", {31'b0, evt_ovf}, 32'd0);
        check("R10", "ctl passthrough with zero mask", {28'b0, ctl_out}, 32'ha);
        ip_req = 1'b1; ip_addr = 8'h07; #1;
        check("R1", "no watch after reset, request forwarded", {31'b0, fab_req}, 32'd1);
        ip_req = 1'b0;
        tick();
        check("R1", "no event after reset", {31'b0, evt_flag}, 32'd0);
    endtask

    task automatic t_config();
        cfg_write(2'd0, 9'h006);
        cfg_write(2'd1, 9'h107);
        cfg_write(2'd2, 9'h005);
        ip_ctl = 4'b0000; eng_force = 4'b1111; #1;
        check("R10", "override mask 0101", {28'b0, ctl_out}, 32'h5);
        ip_ctl = 4'b1010; eng_force = 4'b0000; #1;
        check("R10", "mixed override", {28'b0, ctl_out}, 32'ha);
    endtask

    task automatic t_flag();
        logic [15:0] f;
        obs = 8'b0000_0001;
        tick(); tick();
        check("R3", "unmasked edge ignored", {31'b0, evt_flag}, 32'd0);
        obs = 8'b0000_0111;
        tick();
        check("R3", "flag after masked edge", {31'b0, evt_flag}, 32'd1);
        read_frame("R5", f);
        check("R3", "lowest rising index frame", {16'b0, f}, {16'b0, frame(2'b01, 8'h01, 1'b0)});
        check("R5", "flag cleared after read", {31'b0, evt_flag}, 32'd0);
        obs = '0;
        tick();
    endtask

    task automatic t_access();
        logic [15:0] f;
        ip_req = 1'b1; ip_addr = 8'h03; ip_we = 1'b0; #1;
        check("R4", "other address forwarded", {31'b0, fab_req}, 32'd1);
        ip_addr = 8'h07; ip_we = 1'b1; #1;
        check("R4", "watched access withheld", {31'b0, fab_req}, 32'd0);
        tick();
        check("R4", "access event flag", {31'b0, evt_flag}, 32'd1);
        read_frame("R5", f);
        check("R4", "access frame", {16'b0, f}, {16'b0, frame(2'b10, 8'h07, 1'b1)});
        check("R6", "stalled while pending", {31'b0, fab_req}, 32'd0);
        check("R6", "no deny while pending", {31'b0, ip_deny}, 32'd0);
        eng_allow = 1'b1;
        tick();
        eng_allow = 1'b0;
        check("R6", "released after allow", {31'b0, fab_req}, 32'd1);
        check("R6", "no new event on release", {31'b0, evt_flag}, 32'd0);
        fab_gnt = 1'b1; #1;
        check("R6", "grant passed", {31'b0, ip_gnt}, 32'd1);
        tick();
        fab_gnt = 1'b0; ip_req = 1'b0; ip_we = 1'b0;
        tick();
    endtask

    task automatic t_disable();
        eng_dis_set = 1'b1;
        tick();
        eng_dis_set = 1'b0;
        ip_req = 1'b1; ip_addr = 8'h03; #1;
        check("R7", "blocked after set", {31'b0, fab_req}, 32'd0);
        check("R7", "deny after set", {31'b0, ip_deny}, 32'd1);
        ip_addr = 8'h07;
        tick(); tick();
        check("R7", "no access event while disabled", {31'b0, evt_flag}, 32'd0);
        check("R7", "deny persists", {31'b0, ip_deny}, 32'd1);
        eng_dis_set = 1'b1; eng_dis_clr = 1'b1;
        tick();
        eng_dis_set = 1'b0; eng_dis_clr = 1'b0;
        check("R7", "set wins over clear", {31'b0, ip_deny}, 32'd1);
        ip_addr = 8'h03;
        eng_dis_clr = 1'b1;
        tick();
        eng_dis_clr = 1'b0;
        check("R7", "forwarded after clear", {31'b0, fab_req}, 32'd1);
        check("R7", "deny gone after clear", {31'b0, ip_deny}, 32'd0);
        ip_req = 1'b0;
        tick();
    endtask

    task automatic t_buffer();
        logic [15:0] f;
        obs = 8'b0000_0010;
        tick();
        obs = 8'b0000_0110;
        tick();
        read_frame("R8", f);
        check("R8", "first buffered frame", {16'b0, f}, {16'b0, frame(2'b01, 8'h01, 1'b0)});
        check("R8", "flag kept for second frame", {31'b0, evt_flag}, 32'd1);
        read_frame("R8", f);
        check("R8", "second buffered frame", {16'b0, f}, {16'b0, frame(2'b01, 8'h02, 1'b0)});
        check("R8", "flag cleared when empty", {31'b0, evt_flag}, 32'd0);
        obs = '0;
        tick();
        ip_req = 1'b1; ip_addr = 8'h07; ip_we = 1'b0; obs = 8'b0000_0100;
        tick();
        read_frame("R11", f);
        check("R11", "access frame first", {16'b0, f}, {16'b0, frame(2'b10, 8'h07, 1'b0)});
        read_frame("R11", f);
        check("R11", "flag frame second", {16'b0, f}, {16'b0, frame(2'b01, 8'h02, 1'b0)});
        eng_allow = 1'b1;
        tick();
        eng_allow = 1'b0; fab_gnt = 1'b1;
        tick();
        fab_gnt = 1'b0; ip_req = 1'b0; obs = '0;
        tick();
    endtask

    task automatic t_overflow();
        logic [15:0] f;
        obs = 8'b0000_0010;
        tick();
        obs = 8'b0000_0110;
        tick();
        obs = 8'b0000_0100;
        tick();
        check("R9", "no overflow with two events", {31'b0, evt_ovf}, 32'd0);
        obs = 8'b0000_0110;
        tick();
        check("R9", "overflow on third event", {31'b0, evt_ovf}, 32'd1);
        read_frame("R9", f);
        check("R9", "slot kept first frame", {16'b0, f}, {16'b0, frame(2'b01, 8'h01, 1'b0)});
        read_frame("R9", f);
        check("R9", "buffer kept second frame", {16'b0, f}, {16'b0, frame(2'b01, 8'h02, 1'b0)});
        check("R9", "third frame dropped", {31'b0, evt_flag}, 32'd0);
        check("R9", "overflow sticky", {31'b0, evt_ovf}, 32'd1);
        obs = '0;
        tick();
    endtask

    task automatic t_lock();
        cfg_write(2'd3, 9'h000);
        cfg_write(2'd2, 9'h000);
        ip_ctl = 4'b0000; eng_force = 4'b1111; #1;
        check("R2", "override mask unchanged after lock", {28'b0, ctl_out}, 32'h5);
        cfg_write(2'd0, 9'h000);
        obs = 8'b0000_0010;
        tick();
        check("R2", "monitor mask unchanged after lock", {31'b0, evt_flag}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_config();
        t_flag();
        t_access();
        t_disable();
        t_buffer();
        t_overflow();
        t_lock();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule